// File: doc/BRIEF.md
# Chip-Select Bus Termination Controller

This block decodes one programmable external region on a 68k-style asynchronous bus. It drives that region's chip-select and a two-bit data-size acknowledge, and it shows when a bus cycle has ended. It samples the address strobe, data strobe, read/write, function code, address and size lines on every clock. It compares the cycle against an option set: a base address, a window size, a read/write qualifier, a strobe choice, CPU-space permission and an acknowledge mode. The acknowledge mode picks one of three ways to end the cycle. The first is fast termination. The second is a programmed count of wait states. The third waits only for an external acknowledge. The external acknowledge lines are honoured in every case, including cycles outside the region.

A finite-state machine follows each cycle. It has five states. `ST_IDLE` is the bus at rest. `ST_START` is the first clock after the strobe falls. `ST_WAIT` counts wait states. `ST_IACK` means the cycle ended on the internal acknowledge. `ST_XACK` means it ended on an external one. The transitions are:
- idle→start when the address strobe is sampled low.
- start→iack for a fast-terminated hit.
- start→wait in all other cases.
- wait→xack when an external acknowledge is sampled.
- wait→iack when the programmed count runs out.
- any state→idle when the address strobe is sampled high.

A three-bit phase output reports the bus state number of the current clock.

Top module: `cs_term_ctrl`

## Requirements
- R1: A cycle outside CPU space hits the region when address bits at or above `opt_size_log` equal the same bits of `opt_base`. On a hit with the address strobe selected (`opt_strb_ds`=0), `cs_n` goes low on the first clock edge that samples `as_n` low. It stays low until `as_n` is sampled high.
- R2: With `opt_strb_ds`=1, `cs_n` is low only while the cycle is a hit and `ds_n` is low. A fast-termination write, which never drives `ds_n`, therefore gets no chip-select unless `opt_strb_ds`=0.
- R3: The qualifier `opt_rw` selects which cycles can hit: 2'b01 allows reads only (`rw`=1), 2'b10 allows writes only (`rw`=0), and 2'b00 or 2'b11 allows both.
- R4: A cycle with `fc`=3'b111 is a CPU-space cycle and ignores the address window. It hits only when `opt_cpu_en`=1 and `addr[19:16]` equals `opt_cpu_type`. The type codes are 4'h0 for breakpoint acknowledge, 4'h3 for low-power-stop broadcast and 4'hF for interrupt acknowledge.
- R5: When `opt_ack_mode`=4'b1110 (fast termination), a hit drives `int_ack_n` to 2'b00 after the second clock edge that samples `as_n` low.
- R6: When `opt_ack_mode`=n with n from 0 to 13, a hit drives `int_ack_n` to 2'b00 after clock edge n+3 of the cycle. Both bits low report a 16-bit port.
- R7: When `opt_ack_mode`=4'b1111, `int_ack_n` stays 2'b11 for the whole cycle.
- R8: From the third edge of any cycle onward, including a miss, an `ext_ack_n` value other than 2'b11 ends the cycle at that edge. `cycle_done` goes to 1 and `int_ack_n` stays 2'b11. If the external and internal acknowledges fall on the same edge, the external one wins.
- R9: An external acknowledge held low from the start of the cycle ends it on edge 3, the same edge as an internal zero-wait-state acknowledge.
- R10: The edge that samples `as_n` high returns the block to rest: `cs_n`=1, `int_ack_n`=2'b11, `cycle_done`=0 and `bus_phase`=0. Asserting `rst_n` low forces the same values at once, without waiting for a clock edge.
- R11: `bus_phase` reads 0 at rest, 2 on the first clock of a cycle, 4 while the block waits for termination, and 5 once the cycle has ended.
- R12: `cycle_done` is 1 from the edge that ends the cycle until `as_n` is sampled high, and `int_ack_n`=2'b00 only while `cycle_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 24 | Address bus |
| siz | input | 2 | Transfer size lines (not used in decoding) |
| fc | input | 3 | Function code |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| ext_ack_n | input | 2 | External data-size acknowledge, active low |
| opt_base | input | 24 | Region base address |
| opt_size_log | input | 5 | log2 of the region size in bytes |
| opt_rw | input | 2 | Read/write qualifier |
| opt_strb_ds | input | 1 | 1 = chip-select gated by the data strobe |
| opt_ack_mode | input | 4 | Acknowledge mode |
| opt_cpu_en | input | 1 | Allow CPU-space hits |
| opt_cpu_type | input | 4 | CPU-space cycle type that hits |
| cs_n | output | 1 | Chip-select, active low |
| int_ack_n | output | 2 | Internal acknowledge, active low |
| cycle_done | output | 1 | Cycle has terminated |
| bus_phase | output | 3 | Current bus state number |

## Verification
Every output is registered except `cs_n`. Each result is therefore due just after a specific clock edge, counted from the first edge that samples `as_n` low:
- the chip-select and phase 2 follow edge 1;
- a fast acknowledge follows edge 2;
- a counted acknowledge follows edge n+3;
- an external acknowledge is taken from edge 3 onward;
- the return to rest follows the edge after the strobe rises.

The driver sets the inputs at each falling edge and queues the values it expects after the next rising edge. The monitor compares them 2 ns after that rising edge, so each check lands exactly one register stage after its stimulus. The asynchronous reset is checked directly, a nanosecond after `rst_n` falls.

// File: rtl/cstc_pkg.sv
package cstc_pkg;

    localparam logic [3:0] ACKM_FAST = 4'b1110;
    localparam logic [3:0] ACKM_EXT  = 4'b1111;
    localparam logic [2:0] FC_CPU    = 3'b111;

    localparam logic [1:0] RWQ_READ  = 2'b01;
    localparam logic [1:0] RWQ_WRITE = 2'b10;

    localparam logic [3:0] CPUT_BKPT = 4'h0;
    localparam logic [3:0] CPUT_STOP = 4'h3;
    localparam logic [3:0] CPUT_IACK = 4'hF;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_WAIT  = 3'd2,
        ST_IACK  = 3'd3,
        ST_XACK  = 3'd4
    } term_state_t;

    function automatic logic [2:0] phase_of(input term_state_t s);
        logic [2:0] p;
        unique case (s)
            ST_IDLE:  p = 3'd0;
            ST_START: p = 3'd2;
            ST_WAIT:  p = 3'd4;
            ST_IACK,
            ST_XACK:  p = 3'd5;
            default:  p = 3'd0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/cstc_region_match.sv
module cstc_region_match
    import cstc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SZ_W   = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        fc,
    input  logic              rw,
    input  logic [ADDR_W-1:0] base,
    input  logic [SZ_W-1:0]   size_log,
    input  logic [1:0]        rw_qual,
    input  logic              cpu_en,
    input  logic [3:0]        cpu_type,
    output logic              hit
);
    logic [ADDR_W-1:0] bit_ok;
    logic              in_window;
    logic              rw_ok;
    logic              cpu_space;
    logic              cpu_ok;

    // one comparator per address bit, masked below the window size
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign bit_ok[i] = (SZ_W'(i) < size_log) || (addr[i] == base[i]);
    end

    always_comb begin
        in_window = &bit_ok;
        cpu_space = (fc == FC_CPU);
        cpu_ok    = cpu_en && (addr[19:16] == cpu_type);
        unique case (rw_qual)
            RWQ_READ:  rw_ok = rw;
            RWQ_WRITE: rw_ok = !rw;
            default:   rw_ok = 1'b1;
        endcase
        hit = rw_ok && (cpu_space ? cpu_ok : in_window);
    end

endmodule

// File: rtl/cstc_wait_timer.sv
module cstc_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/cstc_term_fsm.sv
module cstc_term_fsm
    import cstc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        as_n,
    input  logic        hit,
    input  logic [3:0]  ack_mode,
    input  logic [1:0]  ext_ack_n,
    input  logic        cnt_zero,
    output logic        cnt_clr,
    output logic        cnt_load,
    output logic        cnt_dec,
    output logic        region_sel,
    output logic        iack,
    output logic        done,
    output logic [2:0]  phase
);
    term_state_t state_q, state_d;
    logic        hit_q;
    logic        ext_seen;
    logic        counted;

    assign ext_seen = (ext_ack_n != 2'b11);
    assign counted  = (ack_mode != ACKM_FAST) && (ack_mode != ACKM_EXT);

    // next state
    always_comb begin
        state_d  = state_q;
        cnt_clr  = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_clr = 1'b1;
                if (!as_n) state_d = ST_START;
            end
            ST_START: begin
                if (as_n) begin
                    state_d = ST_IDLE;
                end else if (hit_q && (ack_mode == ACKM_FAST)) begin
                    state_d = ST_IACK;
                end else begin
                    state_d  = ST_WAIT;
                    cnt_load = 1'b1;
                end
            end
            ST_WAIT: begin
                if (as_n) begin
                    state_d = ST_IDLE;
                end else if (ext_seen) begin
                    state_d = ST_XACK;
                end else if (hit_q && counted && cnt_zero) begin
                    state_d = ST_IACK;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_IACK,
            ST_XACK: begin
                if (as_n) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hit_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) hit_q <= !as_n && hit;
            else if (state_d == ST_IDLE) hit_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        region_sel = (state_q != ST_IDLE) && hit_q;
        iack       = (state_q == ST_IACK);
        done       = (state_q == ST_IACK) || (state_q == ST_XACK);
        phase      = phase_of(state_q);
    end

    assert_as_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> (state_q == ST_IDLE));
    assert_fast_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && !as_n && hit_q && ack_mode == ACKM_FAST) |=> (state_q == ST_IACK));
    assert_ext_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && ack_mode == ACKM_EXT) |=> (state_q != ST_IACK));
    assert_ext_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !as_n && ext_seen) |=> (state_q == ST_XACK));
    assert_iack_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IACK) |-> hit_q);

endmodule

// File: rtl/cs_term_ctrl.sv
module cs_term_ctrl
    import cstc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SZ_W   = 5,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        siz,
    input  logic [2:0]        fc,
    input  logic              as_n,
    input  logic              ds_n,
    input  logic              rw,
    input  logic [1:0]        ext_ack_n,
    input  logic [ADDR_W-1:0] opt_base,
    input  logic [SZ_W-1:0]   opt_size_log,
    input  logic [1:0]        opt_rw,
    input  logic              opt_strb_ds,
    input  logic [CNT_W-1:0]  opt_ack_mode,
    input  logic              opt_cpu_en,
    input  logic [3:0]        opt_cpu_type,
    output logic              cs_n,
    output logic [1:0]        int_ack_n,
    output logic              cycle_done,
    output logic [2:0]        bus_phase
);
    logic hit, cnt_zero, cnt_clr, cnt_load, cnt_dec;
    logic region_sel, iack;
    logic siz_unused;

    assign siz_unused = ^siz;

    cstc_region_match #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_match (
        .addr(addr), .fc(fc), .rw(rw), .base(opt_base), .size_log(opt_size_log),
        .rw_qual(opt_rw), .cpu_en(opt_cpu_en), .cpu_type(opt_cpu_type), .hit(hit)
    );

    cstc_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .load(cnt_load),
        .load_val(opt_ack_mode), .dec(cnt_dec), .zero(cnt_zero)
    );

    cstc_term_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .hit(hit), .ack_mode(opt_ack_mode),
        .ext_ack_n(ext_ack_n), .cnt_zero(cnt_zero), .cnt_clr(cnt_clr),
        .cnt_load(cnt_load), .cnt_dec(cnt_dec), .region_sel(region_sel),
        .iack(iack), .done(cycle_done), .phase(bus_phase)
    );

    // strobe gating: the data-strobe choice keys the select from ds_n
    always_comb begin
        cs_n      = !(region_sel && (!opt_strb_ds || !ds_n));
        int_ack_n = iack ? 2'b00 : 2'b11;
    end

    assert_ack_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack_n != 2'b11) |-> cycle_done);
    assert_done_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cycle_done) |-> $past(!as_n));
    assert_cpu_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fc == FC_CPU && !opt_cpu_en && !as_n && bus_phase == 3'd0) |=> cs_n);
    assert_start_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_phase == 3'd0 && !as_n) |=> (bus_phase == 3'd2));

endmodule

// File: tb/cs_term_ctrl_test.sv
module cs_term_ctrl_test;

    typedef struct {
        logic       cs_n;
        logic [1:0] ack;
        logic       done;
        logic [2:0] ph;
        string      req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] addr = '0;
    logic [1:0]  siz = 2'b10;
    logic [2:0]  fc = 3'b101;
    logic        as_n = 1'b1, ds_n = 1'b1, rw = 1'b1;
    logic [1:0]  ext_ack_n = 2'b11;
    logic [23:0] opt_base = 24'h040000;
    logic [4:0]  opt_size_log = 5'd16;
    logic [1:0]  opt_rw = 2'b00;
    logic        opt_strb_ds = 1'b0;
    logic [3:0]  opt_ack_mode = 4'd0;
    logic        opt_cpu_en = 1'b0;
    logic [3:0]  opt_cpu_type = 4'h0;
    logic        cs_n, cycle_done;
    logic [1:0]  int_ack_n;
    logic [2:0]  bus_phase;

    int   n_checks = 0, n_fail = 0;
    exp_t q[$];

    always #4 clk = !clk;

    cs_term_ctrl uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .siz(siz), .fc(fc), .as_n(as_n),
        .ds_n(ds_n), .rw(rw), .ext_ack_n(ext_ack_n), .opt_base(opt_base),
        .opt_size_log(opt_size_log), .opt_rw(opt_rw), .opt_strb_ds(opt_strb_ds),
        .opt_ack_mode(opt_ack_mode), .opt_cpu_en(opt_cpu_en),
        .opt_cpu_type(opt_cpu_type), .cs_n(cs_n), .int_ack_n(int_ack_n),
        .cycle_done(cycle_done), .bus_phase(bus_phase)
    );

    task automatic compare(input exp_t e);
        n_checks++;
        if (cs_n !== e.cs_n || int_ack_n !== e.ack || cycle_done !== e.done || bus_phase !== e.ph) begin
            n_fail++;
            $display("FAIL %s: got cs_n=%b ack=%b done=%b ph=%0d, expected cs_n=%b ack=%b done=%b ph=%0d",
                     e.req, cs_n, int_ack_n, cycle_done, bus_phase, e.cs_n, e.ack, e.done, e.ph);
        end
    endtask

    // monitor: compare 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    // region hit as the requirements define it (R1, R3, R4)
    function automatic bit exp_hit(input logic [23:0] a, input logic [2:0] f, input logic r);
        bit rw_ok, win;
        rw_ok = (opt_rw == 2'b01) ? r : (opt_rw == 2'b10) ? !r : 1'b1;
        win   = ((a >> opt_size_log) == (opt_base >> opt_size_log));
        if (f == 3'b111) return rw_ok && opt_cpu_en && (a[19:16] == opt_cpu_type);
        return rw_ok && win;
    endfunction

    task automatic do_cycle(input logic [23:0] a, input logic [2:0] f, input logic r,
                            input bit ds_on, input int ext_from, input int len, input string req);
        bit   h;
        int   term;
        exp_t e;
        h    = exp_hit(a, f, r);
        term = 0;
        for (int k = 1; k <= len; k++) begin
            @(negedge clk);
            addr = a; fc = f; rw = r; as_n = 1'b0; ds_n = !ds_on;
            ext_ack_n = (ext_from > 0 && k >= ext_from) ? 2'b00 : 2'b11;
            if (term == 0) begin
                if (k >= 3 && ext_from > 0 && k >= ext_from) term = 2;
                else if (k == 2 && h && opt_ack_mode == 4'hE) term = 1;
                else if (k >= 3 && h && opt_ack_mode < 4'hE && k == int'(opt_ack_mode) + 3) term = 1;
            end
            e.cs_n = !(h && (!opt_strb_ds || ds_on));
            e.ack  = (term == 1) ? 2'b00 : 2'b11;
            e.done = (term != 0);
            e.ph   = (term != 0) ? 3'd5 : ((k == 1) ? 3'd2 : 3'd4);
            e.req  = req;
            q.push_back(e);
        end
        @(negedge clk);
        as_n = 1'b1; ds_n = 1'b1; ext_ack_n = 2'b11;
        e.cs_n = 1'b1; e.ack = 2'b11; e.done = 1'b0; e.ph = 3'd0; e.req = "R10 idle";
        q.push_back(e);
    endtask

    task automatic drain();
        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        #1000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        exp_t e;
        repeat (3) @(posedge clk);
        #1;
        e.cs_n = 1'b1; e.ack = 2'b11; e.done = 1'b0; e.ph = 3'd0; e.req = "R10 reset";
        compare(e);
        @(negedge clk) rst_n = 1'b1;

        // R1 R6 R11: zero-wait hit, counted modes, upper bound
        do_cycle(24'h041234, 3'b101, 1'b1, 1'b1, 0, 5,  "R6 mode0");
        opt_ack_mode = 4'd5;
        do_cycle(24'h04ABCD, 3'b101, 1'b1, 1'b1, 0, 10, "R6 mode5");
        opt_ack_mode = 4'd13;
        do_cycle(24'h040000, 3'b101, 1'b0, 1'b1, 0, 18, "R6 mode13");
        // R1 window boundaries
        opt_ack_mode = 4'd0;
        do_cycle(24'h03FFFF, 3'b101, 1'b1, 1'b1, 0, 4, "R1 below window");
        do_cycle(24'h04FFFF, 3'b101, 1'b1, 1'b1, 0, 4, "R1 top of window");
        // R5 R2 fast termination
        opt_ack_mode = 4'hE;
        do_cycle(24'h041000, 3'b101, 1'b1, 1'b1, 0, 4, "R5 fast read");
        do_cycle(24'h041000, 3'b101, 1'b0, 1'b0, 0, 4, "R5 R2 fast write AS-keyed");
        opt_strb_ds = 1'b1;
        do_cycle(24'h041000, 3'b101, 1'b0, 1'b0, 0, 4, "R2 fast write DS-keyed");
        do_cycle(24'h041000, 3'b101, 1'b1, 1'b1, 0, 4, "R2 fast read DS-keyed");
        opt_strb_ds = 1'b0;
        // R7 R8 external-only and external termination
        opt_ack_mode = 4'hF;
        do_cycle(24'h042000, 3'b101, 1'b1, 1'b1, 0, 8, "R7 no internal ack");
        do_cycle(24'h042000, 3'b101, 1'b1, 1'b1, 5, 7, "R8 ext on hit");
        opt_ack_mode = 4'd0;
        do_cycle(24'h050000, 3'b101, 1'b1, 1'b1, 4, 6, "R8 ext on miss");
        opt_ack_mode = 4'd5;
        do_cycle(24'h040100, 3'b101, 1'b1, 1'b1, 3, 5, "R8 ext ends early");
        // R9 ext held low from the start
        opt_ack_mode = 4'd0;
        do_cycle(24'h040100, 3'b101, 1'b1, 1'b1, 1, 5, "R9 ext held");
        // R3 qualifier
        opt_rw = 2'b01;
        do_cycle(24'h040200, 3'b101, 1'b0, 1'b1, 0, 4, "R3 read-only write");
        do_cycle(24'h040200, 3'b101, 1'b1, 1'b1, 0, 4, "R3 read-only read");
        opt_rw = 2'b10;
        do_cycle(24'h040200, 3'b101, 1'b1, 1'b1, 0, 4, "R3 write-only read");
        do_cycle(24'h040200, 3'b101, 1'b0, 1'b1, 0, 4, "R3 write-only write");
        opt_rw = 2'b00;
        // R4 CPU space
        opt_base = 24'h000000; opt_size_log = 5'd24;
        do_cycle(24'h0F0000, 3'b111, 1'b1, 1'b1, 0, 4, "R4 cpu space disabled");
        do_cycle(24'h0F0000, 3'b101, 1'b1, 1'b1, 0, 4, "R1 whole-space window");
        opt_cpu_en = 1'b1; opt_cpu_type = 4'h3;
        do_cycle(24'h030000, 3'b111, 1'b1, 1'b1, 0, 4, "R4 stop broadcast hit");
        do_cycle(24'h000000, 3'b111, 1'b1, 1'b1, 0, 4, "R4 breakpoint miss");
        opt_cpu_type = 4'hF;
        do_cycle(24'h0F0000, 3'b111, 1'b1, 1'b1, 0, 4, "R4 int ack hit");
        opt_cpu_en = 1'b0; opt_base = 24'h040000; opt_size_log = 5'd16;
        // R10 strobe negated mid wait
        opt_ack_mode = 4'd13;
        do_cycle(24'h040300, 3'b101, 1'b1, 1'b1, 0, 4, "R10 early negate");
        drain();

        // R10 asynchronous reset in mid cycle
        @(negedge clk);
        addr = 24'h040300; fc = 3'b101; rw = 1'b1; as_n = 1'b0; ds_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b0;
        #1;
        e.cs_n = 1'b1; e.ack = 2'b11; e.done = 1'b0; e.ph = 3'd0; e.req = "R10 async reset";
        compare(e);
        @(negedge clk);
        as_n = 1'b1; ds_n = 1'b1;
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(posedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule